// File: doc/BRIEF.md
# ADC Sample Clip, Overload Flag and Startup Mute

This block sits behind the decimation and optional DC-removal filters of a stereo audio converter. Every time a new sample pair arrives, it limits each channel to the signed range of the output word and registers the result. It also watches the limited samples for amplitude near full scale. When either channel comes close to full scale, it raises an overload flag that stays up for a fixed number of sample periods, and every further loud sample restarts that period.

When the standby input is released, the block sends out zeros and keeps its data-qualify output low until a startup window of samples has gone by, so that downstream logic never sees filter settling. The window is short when the high-pass filter is off and much longer when it is on. If the filter setting changes while the window is still running, the window restarts at the length of the new setting.

While standby is held, the block tells the pad logic to release the interface outputs through a drive-enable output, and it clears its state. Serial framing happens downstream and is not part of this block.

Top module: `adc_clip_ovl_mute`

## Requirements
- R1: A sample above 2^(OUT_W-1)-1 is output as 2^(OUT_W-1)-1. With the default OUT_W of 18 this is 131071. The value appears in the cycle after its valid strobe.
- R2: A sample below -2^(OUT_W-1) is output as -2^(OUT_W-1), which is -131072 by default. A sample inside the range is output unchanged.
- R3: The overload flag is set in the cycle after a valid strobe when the absolute value of either limited channel is strictly greater than floor(0.8888 * 2^(OUT_W-1)), which is 116496 by default. A magnitude equal to the threshold does not set it.
- R4: After the last sample over the threshold, the flag stays high through OVL_HOLD-1 further samples under the threshold. It goes low with the OVL_HOLD-th such sample. Each new sample over the threshold restarts this count.
- R5: With the high-pass enable low, the first MUTE_SHORT valid samples after standby is released are output as zero, with data-qualify low. From the next sample on, samples pass and data-qualify is high. Data-qualify stays high until standby is asserted again.
- R6: With the high-pass enable high, the startup window is MUTE_LONG samples instead of MUTE_SHORT.
- R7: If the high-pass enable changes while the startup window is still running, the window restarts with the full length for the new setting, counted from the change.
- R8: While standbyN is low, outEnable is low, data-qualify is low, the overload flag is cleared and the sample outputs read zero. Valid strobes have no effect during this time.
- R9: While reset is asserted, the sample outputs, the overload flag and data-qualify are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| standbyN | input | 1 | Standby when low |
| hpEnable | input | 1 | High-pass filter enabled; selects the startup window length |
| sampleValid | input | 1 | One-cycle strobe marking a new sample pair |
| inLeft | input | IN_W | Left sample, signed |
| inRight | input | IN_W | Right sample, signed |
| outLeft | output | OUT_W | Limited left sample, signed |
| outRight | output | OUT_W | Limited right sample, signed |
| overload | output | 1 | Near-full-scale flag with retriggerable hold |
| dataQualify | output | 1 | High once the startup window has passed |
| outEnable | output | 1 | Drive enable for the interface pads, low in standby |

## Verification
The bench builds the block with IN_W=20 and OUT_W=18. This keeps the real saturation points and the real 116496 threshold, and a 20-bit input can reach both limits and go well past them. OVL_HOLD is set to 4 and the two startup windows to 6 and 10. With these values the exact release sample of the overload hold, a retrigger partway through the hold, both window lengths and the restart on a filter-setting change each take only a few samples to reach.

// File: rtl/adcpp_pkg.sv
package adcpp_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch a new sample pair
    logic live;     // startup window passed; let samples through
  } ppStrobe_t;
endpackage

// File: rtl/adcpp_datapath.sv
module adcpp_datapath
  import adcpp_pkg::*;
#(
  parameter int IN_W  = 24,
  parameter int OUT_W = 18
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ppStrobe_t               strobe,
  input  logic signed [IN_W-1:0]  inSample [2],
  output logic signed [OUT_W-1:0] outSample [2],
  output logic                    trip
);
  localparam longint HALF     = 64'sd1 <<< (OUT_W - 1);
  localparam longint POS_LIM  = HALF - 1;
  localparam longint NEG_LIM  = -HALF;
  localparam longint THRESH   = (HALF * 8888) / 10000;
  localparam logic signed [IN_W-1:0] POS_IN = IN_W'(POS_LIM);
  localparam logic signed [IN_W-1:0] NEG_IN = IN_W'(NEG_LIM);
  localparam logic [OUT_W:0]         THR_V  = (OUT_W+1)'(THRESH);

  logic [1:0] overCh;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic signed [OUT_W-1:0] clipVal;
    logic signed [OUT_W-1:0] sampleReg;
    logic signed [OUT_W:0]   extVal;
    logic [OUT_W:0]          magVal;

    always_comb begin
      if (inSample[ch] > POS_IN)      clipVal = POS_IN[OUT_W-1:0];
      else if (inSample[ch] < NEG_IN) clipVal = NEG_IN[OUT_W-1:0];
      else                            clipVal = inSample[ch][OUT_W-1:0];
      extVal = {clipVal[OUT_W-1], clipVal};
      magVal = extVal[OUT_W] ? $unsigned(-extVal) : $unsigned(extVal);
    end

    assign overCh[ch] = magVal > THR_V;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               sampleReg <= '0;
      else if (strobe.capture) sampleReg <= clipVal;
    end

    assign outSample[ch] = strobe.live ? sampleReg : '0;

    // R1: oversized positive input lands on the top code
    p_clip_pos_r1: assert property (@(posedge clk) disable iff (!rstN)
      strobe.capture && (inSample[ch] > POS_IN) |=> sampleReg == POS_IN[OUT_W-1:0]);
    // R2: oversized negative input lands on the bottom code
    p_clip_neg_r2: assert property (@(posedge clk) disable iff (!rstN)
      strobe.capture && (inSample[ch] < NEG_IN) |=> sampleReg == NEG_IN[OUT_W-1:0]);
    // R2: in-range input passes unchanged
    p_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
      strobe.capture && (inSample[ch] <= POS_IN) && (inSample[ch] >= NEG_IN)
      |=> sampleReg == $past(inSample[ch][OUT_W-1:0]));
  end

  assign trip = |overCh;
endmodule

// File: rtl/adcpp_control.sv
module adcpp_control
  import adcpp_pkg::*;
#(
  parameter int OVL_HOLD   = 512,
  parameter int MUTE_SHORT = 1024,
  parameter int MUTE_LONG  = 12288
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      standbyN,
  input  logic      hpEnable,
  input  logic      sampleValid,
  input  logic      trip,
  output ppStrobe_t strobe,
  output logic      overload
);
  localparam int MUTE_MAX = (MUTE_LONG > MUTE_SHORT) ? MUTE_LONG : MUTE_SHORT;
  localparam int MW = $clog2(MUTE_MAX + 1);
  localparam int HW = $clog2(OVL_HOLD + 1);
  localparam logic [MW-1:0] LEN_S = MW'(MUTE_SHORT);
  localparam logic [MW-1:0] LEN_L = MW'(MUTE_LONG);
  localparam logic [HW-1:0] HOLD_V = HW'(OVL_HOLD);

  logic [MW-1:0] muteCnt;
  logic [HW-1:0] holdCnt;
  logic          hpPrev;
  logic          liveReg;
  logic [MW-1:0] lenSel;
  logic          takeSample;

  assign lenSel     = hpEnable ? LEN_L : LEN_S;
  assign takeSample = sampleValid && standbyN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      muteCnt <= LEN_S;
      holdCnt <= '0;
      hpPrev  <= 1'b0;
      liveReg <= 1'b0;
    end else if (!standbyN) begin
      muteCnt <= lenSel;
      holdCnt <= '0;
      hpPrev  <= hpEnable;
      liveReg <= 1'b0;
    end else begin
      hpPrev <= hpEnable;
      if ((hpEnable != hpPrev) && (muteCnt != '0)) muteCnt <= lenSel;
      else if (sampleValid && (muteCnt != '0))    muteCnt <= muteCnt - 1'b1;
      if (sampleValid) liveReg <= (muteCnt == '0);
      if (sampleValid && trip)                   holdCnt <= HOLD_V;
      else if (sampleValid && (holdCnt != '0))   holdCnt <= holdCnt - 1'b1;
    end
  end

  assign strobe.capture = takeSample;
  assign strobe.live    = liveReg;
  assign overload       = holdCnt != '0;

  // R3: a loud sample raises the flag on the next cycle
  p_trip_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    takeSample && trip |=> overload);
  // R4: the flag cannot drop without a valid sample
  p_hold_needs_sample_r4: assert property (@(posedge clk) disable iff (!rstN)
    overload && !sampleValid && standbyN |=> overload);
  // R5: once live, data stays qualified while out of standby
  p_live_sticks_r5: assert property (@(posedge clk) disable iff (!rstN)
    liveReg && standbyN |=> liveReg);
  // R8: standby clears flag and qualify
  p_standby_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    !standbyN |=> !overload && !liveReg);
  // R7: a filter-setting change during the window keeps data muted
  p_reload_mute_r7: assert property (@(posedge clk) disable iff (!rstN)
    standbyN && !liveReg && (hpEnable != hpPrev) |=> !liveReg);
endmodule

// File: rtl/adc_clip_ovl_mute.sv
module adc_clip_ovl_mute
  import adcpp_pkg::*;
#(
  parameter int IN_W       = 24,
  parameter int OUT_W      = 18,
  parameter int OVL_HOLD   = 512,
  parameter int MUTE_SHORT = 1024,
  parameter int MUTE_LONG  = 12288
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    standbyN,
  input  logic                    hpEnable,
  input  logic                    sampleValid,
  input  logic signed [IN_W-1:0]  inLeft,
  input  logic signed [IN_W-1:0]  inRight,
  output logic signed [OUT_W-1:0] outLeft,
  output logic signed [OUT_W-1:0] outRight,
  output logic                    overload,
  output logic                    dataQualify,
  output logic                    outEnable
);
  ppStrobe_t               strobe;
  logic                    trip;
  logic signed [IN_W-1:0]  inPair  [2];
  logic signed [OUT_W-1:0] outPair [2];

  assign inPair[0] = inLeft;
  assign inPair[1] = inRight;

  adcpp_control #(
    .OVL_HOLD(OVL_HOLD), .MUTE_SHORT(MUTE_SHORT), .MUTE_LONG(MUTE_LONG)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .standbyN(standbyN), .hpEnable(hpEnable),
    .sampleValid(sampleValid), .trip(trip), .strobe(strobe), .overload(overload)
  );

  adcpp_datapath #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inSample(inPair),
    .outSample(outPair), .trip(trip)
  );

  assign outLeft     = outPair[0];
  assign outRight    = outPair[1];
  assign dataQualify = strobe.live;
  assign outEnable   = standbyN;
endmodule

// File: tb/adc_clip_ovl_mute_tb.sv
`timescale 1ns/1ps
module adc_clip_ovl_mute_tb;
  localparam int IN_W = 20, OUT_W = 18, HOLD = 4, MS = 6, ML = 10;

  typedef struct packed {
    logic signed [IN_W-1:0]  l;
    logic signed [IN_W-1:0]  r;
    logic signed [OUT_W-1:0] el;
    logic signed [OUT_W-1:0] er;
    logic                    trip;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{0, 0, 0, 0, 1'b0},
    '{1000, -1000, 1000, -1000, 1'b0},
    '{131071, 0, 131071, 0, 1'b1},
    '{131072, -131072, 131071, -131072, 1'b1},
    '{200000, -300000, 131071, -131072, 1'b1},
    '{116496, -116496, 116496, -116496, 1'b0},
    '{116497, 0, 116497, 0, 1'b1},
    '{0, -116497, 0, -116497, 1'b1},
    '{-131073, 5, -131072, 5, 1'b1},
    '{524287, -524288, 131071, -131072, 1'b1},
    '{50000, 60000, 50000, 60000, 1'b0},
    '{0, 0, 0, 0, 1'b0},
    '{0, 0, 0, 0, 1'b0},
    '{0, 0, 0, 0, 1'b0},
    '{0, 0, 0, 0, 1'b0},
    '{0, 0, 0, 0, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0, standbyN = 1'b0, hpEnable = 1'b0, sampleValid = 1'b0;
  logic signed [IN_W-1:0]  inLeft = '0, inRight = '0;
  logic signed [OUT_W-1:0] outLeft, outRight;
  logic overload, dataQualify, outEnable;
  int nChecks = 0, nFail = 0, modelHold = 0;

  always #2 clk = ~clk;

  adc_clip_ovl_mute #(.IN_W(IN_W), .OUT_W(OUT_W), .OVL_HOLD(HOLD),
    .MUTE_SHORT(MS), .MUTE_LONG(ML)) u_dut (
    .clk(clk), .rstN(rstN), .standbyN(standbyN), .hpEnable(hpEnable),
    .sampleValid(sampleValid), .inLeft(inLeft), .inRight(inRight),
    .outLeft(outLeft), .outRight(outRight), .overload(overload),
    .dataQualify(dataQualify), .outEnable(outEnable));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input longint l, input longint r);
    @(negedge clk);
    inLeft = IN_W'(l); inRight = IN_W'(r); sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic sendN(input int n, input longint v);
    for (int i = 0; i < n; i++) send(v, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(outLeft == 0 && outRight == 0, "R9 samples", outLeft, 0);
    check(!overload, "R9 overload", overload, 0);
    check(!dataQualify, "R9 qualify", dataQualify, 0);
    rstN = 1'b1;
    // R8 standby ignores a loud sample
    send(131071, 131071);
    check(!overload, "R8 ovl in standby", overload, 0);
    check(!dataQualify && outLeft == 0, "R8 qualify/sample in standby", dataQualify, 0);
    check(!outEnable, "R8 outEnable", outEnable, 0);

    // R5 short window
    @(negedge clk); standbyN = 1'b1;
    @(negedge clk);
    check(outEnable, "R8 outEnable released", outEnable, 1);
    sendN(MS, 1000);
    check(!dataQualify, "R5 qualify after window", dataQualify, 0);
    check(outLeft == 0, "R5 muted sample", outLeft, 0);
    send(1000, 1000);
    check(dataQualify, "R5 qualify live", dataQualify, 1);
    check(outLeft == 1000, "R5 live sample", outLeft, 1000);

    // R1 R2 R3 R4 table walk
    modelHold = 0;
    foreach (VECS[i]) begin
      send(VECS[i].l, VECS[i].r);
      if (VECS[i].trip) modelHold = HOLD; else if (modelHold > 0) modelHold--;
      check(outLeft == VECS[i].el, "R1/R2 left", outLeft, VECS[i].el);
      check(outRight == VECS[i].er, "R1/R2 right", outRight, VECS[i].er);
      check(overload == (modelHold != 0), "R3/R4 overload", overload, modelHold != 0);
    end

    // R4 exact hold release
    send(130000, 0); sendN(HOLD - 1, 0);
    check(overload, "R4 held", overload, 1);
    send(0, 0);
    check(!overload, "R4 released", overload, 0);
    // R4 retrigger
    send(0, -130000); sendN(2, 0); send(120000, 0); sendN(HOLD - 1, 0);
    check(overload, "R4 retrigger held", overload, 1);
    send(0, 0);
    check(!overload, "R4 retrigger released", overload, 0);

    // R8 standby clears flag
    send(130000, 0);
    @(negedge clk); standbyN = 1'b0;
    repeat (2) @(negedge clk);
    check(!overload, "R8 ovl cleared", overload, 0);
    check(!dataQualify, "R8 qualify cleared", dataQualify, 0);
    check(outLeft == 0, "R8 sample zero", outLeft, 0);

    // R6 long window
    hpEnable = 1'b1;
    @(negedge clk); standbyN = 1'b1;
    sendN(ML, 2000);
    check(!dataQualify, "R6 still muted", dataQualify, 0);
    send(2000, 2000);
    check(dataQualify && outLeft == 2000, "R6 live", dataQualify, 1);

    // R7 reload on filter change
    @(negedge clk); standbyN = 1'b0; hpEnable = 1'b0;
    repeat (2) @(negedge clk); standbyN = 1'b1;
    sendN(3, 3000);
    @(negedge clk); hpEnable = 1'b1;
    repeat (2) @(negedge clk);
    sendN(ML, 3000);
    check(!dataQualify, "R7 muted after reload", dataQualify, 0);
    check(outLeft == 0, "R7 muted sample", outLeft, 0);
    send(3000, 3000);
    check(dataQualify, "R7 live after reload", dataQualify, 1);

    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule